// File: doc/BRIEF.md
# Predicated Three-Way Interleaving Store Unit

This block turns three vector operands of 32-bit elements into a stream of single-word memory writes. Element i of the first, second and third vector become three consecutive words that form structure i. Structures are laid out back to back starting at an effective address. That address is a 64-bit base plus a signed immediate scaled by the vector length in bytes. A per-element predicate decides, for each structure as a whole, whether its three writes are issued. An inactive structure produces no write request at all, so its memory stays untouched and it can never raise a fault.

An operation begins with a one-cycle `start` while the unit is idle. `busy` stays high while writes go out on a valid/ready port, one word per accepted beat. `done` pulses once at the end. The unit validates the immediate and reports the three register indices the operation names, wrapping modulo the register count. A fault returned by memory on an accepted beat aborts the operation and reports which element faulted. The vector length is a parameter taking 128, 256, 512, 1024 or 2048 bits.

Top module: `tri_store_interleave`

## Requirements
- R1: Word w (0, 1, 2) of structure i carries element i of `vec_a`, `vec_b`, `vec_c` respectively, where element i occupies bits [32*i+31:32*i] of its vector. It is written to address EA + 12*i + 4*w.
- R2: EA equals `base_addr` plus the sign-extended 6-bit `imm_vl` multiplied by VLEN/8.
- R3: Element i is active when `pred[4*i]` is 1. All other predicate bits are ignored. An inactive element produces no write beat for any of its three words.
- R4: Each accepted beat (`mem_valid` and `mem_ready` high at an edge) carries exactly one word with `mem_strb` = 4'b1111. Beats go out in ascending address order. While `mem_valid` is high and `mem_ready` is low, address and data hold.
- R5: `imm_vl` is legal only if it is a multiple of 3 within -24..21. An illegal value produces no beats. It raises `err_illegal` with `done` in the cycle after `start`.
- R6: `reg_sel` reports {(f+2) mod 32, (f+1) mod 32, f} for `first_reg` = f, packed with f in bits [4:0].
- R7: A beat accepted with `mem_fault` high ends the operation. No further beat is offered, and `done` rises in the next cycle with `err_fault` high. `fault_elem` holds that beat's element index.
- R8: `start` is accepted only while idle. `busy` is high from the cycle after an accepted `start` until `done`, and is never high together with `done`. `done` lasts one cycle. It rises in the cycle after the final accepted beat, or in the cycle after `start` when no element is active.
- R9: After reset `busy`, `done`, `mem_valid`, `err_illegal` and `err_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| base_addr | input | 64 | Base byte address |
| imm_vl | input | 6 | Signed offset in units of the vector length |
| first_reg | input | 5 | Index of the first source register |
| vec_a | input | VLEN | First source vector |
| vec_b | input | VLEN | Second source vector |
| vec_c | input | VLEN | Third source vector |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_illegal | output | 1 | Immediate was out of its legal set |
| err_fault | output | 1 | Memory reported a fault |
| fault_elem | output | log2(VLEN/32) | Element index of the faulting beat |
| reg_sel | output | 15 | Three selected register indices |
| mem_valid | output | 1 | Write beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 64 | Byte address of the word |
| mem_data | output | 32 | Word to write |
| mem_strb | output | 4 | Byte strobes |
| mem_fault | input | 1 | Fault for the beat accepted this cycle |

## Verification
The first beat is offered in the cycle after `start` is taken. With `mem_ready` high, each active element then costs exactly three cycles. `done`, the error flags, `fault_elem` and `reg_sel` are due one cycle after the last accepted beat, or one cycle after `start` when nothing is written or the immediate is illegal. The bench counts cycles from the start edge and samples every output half a period after each edge. It records the cycle of the last accepted beat and requires `done` exactly one cycle later. Under a stalling `mem_ready` pattern it compares every offered beat against the value held from the previous cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int ELEM_W       = 32;
   localparam int WORDS_PER_ST = 3;
   localparam int WORD_BYTES   = ELEM_W / 8;
   localparam int STRUCT_BYTES = WORDS_PER_ST * WORD_BYTES;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } tsi_state_e;
endpackage

// File: rtl/tsi_operand_check.sv
module tsi_operand_check #(
   parameter int VLEN    = 128,
   parameter int AW      = 64,
   parameter int IMM_W   = 6,
   parameter int IMM_MIN = -24,
   parameter int IMM_MAX = 21,
   parameter int IMM_MUL = 3,
   parameter int NREG    = 32,
   parameter int RSEL_W  = 5,
   parameter int NSRC    = 3
) (
   input  logic [AW-1:0]          base,
   input  logic [IMM_W-1:0]       imm,
   input  logic [RSEL_W-1:0]      first,
   output logic [AW-1:0]          eff,
   output logic                   legal,
   output logic [NSRC*RSEL_W-1:0] sel
);
   localparam int VL_BYTES = VLEN / 8;
   localparam int VB_SHIFT = $clog2(VL_BYTES);

   logic signed [IMM_W-1:0] imm_s;
   logic        [AW-1:0]    imm_ext;
   int                      imm_i;

   assign imm_s   = imm;
   assign imm_i   = int'(imm_s);
   assign imm_ext = AW'(imm_s);
   assign eff     = base + (imm_ext << VB_SHIFT);
   assign legal   = (imm_i >= IMM_MIN) && (imm_i <= IMM_MAX) && ((imm_i % IMM_MUL) == 0);

   for (genvar k = 0; k < NSRC; k++) begin : g_sel
      assign sel[k*RSEL_W +: RSEL_W] = RSEL_W'((int'(first) + k) % NREG);
   end
endmodule

// File: rtl/tsi_first_set.sv
module tsi_first_set #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot,
   output logic          any
);
   always_comb begin
      idx    = '0;
      onehot = '0;
      any    = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx       = IW'(i);
            onehot    = '0;
            onehot[i] = 1'b1;
            any       = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tsi_word_mux.sv
module tsi_word_mux #(
   parameter int LANES = 4,
   parameter int IW    = 2,
   parameter int EW    = 32
) (
   input  logic [LANES*EW-1:0] va,
   input  logic [LANES*EW-1:0] vb,
   input  logic [LANES*EW-1:0] vc,
   input  logic [IW-1:0]       idx,
   input  logic [1:0]          wsel,
   output logic [EW-1:0]       word
);
   logic [EW-1:0] la [LANES];
   logic [EW-1:0] lb [LANES];
   logic [EW-1:0] lc [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign la[i] = va[i*EW +: EW];
      assign lb[i] = vb[i*EW +: EW];
      assign lc[i] = vc[i*EW +: EW];
   end

   always_comb begin
      unique case (wsel)
         2'd0:    word = la[idx];
         2'd1:    word = lb[idx];
         default: word = lc[idx];
      endcase
   end
endmodule

// File: rtl/tri_store_interleave.sv
module tri_store_interleave
   import tsi_pkg::*;
#(
   parameter int VLEN   = 128,
   parameter int AW     = 64,
   parameter int IMM_W  = 6,
   parameter int NREG   = 32,
   parameter int RSEL_W = 5,
   localparam int NE    = VLEN / ELEM_W,
   localparam int IW    = $clog2(NE),
   localparam int PW    = VLEN / 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [AW-1:0]              base_addr,
   input  logic [IMM_W-1:0]           imm_vl,
   input  logic [RSEL_W-1:0]          first_reg,
   input  logic [VLEN-1:0]            vec_a,
   input  logic [VLEN-1:0]            vec_b,
   input  logic [VLEN-1:0]            vec_c,
   input  logic [PW-1:0]              pred,
   output logic                       busy,
   output logic                       done,
   output logic                       err_illegal,
   output logic                       err_fault,
   output logic [IW-1:0]              fault_elem,
   output logic [3*RSEL_W-1:0]        reg_sel,
   output logic                       mem_valid,
   input  logic                       mem_ready,
   output logic [AW-1:0]              mem_addr,
   output logic [ELEM_W-1:0]          mem_data,
   output logic [WORD_BYTES-1:0]      mem_strb,
   input  logic                       mem_fault
);
   localparam int PRED_STRIDE = ELEM_W / 8;

   initial begin
      assert (VLEN == 128 || VLEN == 256 || VLEN == 512 || VLEN == 1024 || VLEN == 2048)
         else $error("tri_store_interleave: unsupported VLEN %0d", VLEN);
      assert (NREG <= (1 << RSEL_W))
         else $error("tri_store_interleave: RSEL_W too narrow for NREG");
      assert (AW >= 32)
         else $error("tri_store_interleave: AW too small");
   end

   // ---------------------------------------------------------------
   // Operand evaluation
   // ---------------------------------------------------------------
   logic [AW-1:0]           eff_c;
   logic                    legal_c;
   logic [3*RSEL_W-1:0]     sel_c;
   logic [NE-1:0]           act_c;

   tsi_operand_check #(
      .VLEN(VLEN), .AW(AW), .IMM_W(IMM_W), .IMM_MIN(-24), .IMM_MAX(21),
      .IMM_MUL(3), .NREG(NREG), .RSEL_W(RSEL_W), .NSRC(WORDS_PER_ST)
   ) u_opchk (
      .base  (base_addr),
      .imm   (imm_vl),
      .first (first_reg),
      .eff   (eff_c),
      .legal (legal_c),
      .sel   (sel_c)
   );

   for (genvar i = 0; i < NE; i++) begin : g_pred
      assign act_c[i] = pred[i*PRED_STRIDE];
   end

   // ---------------------------------------------------------------
   // State
   // ---------------------------------------------------------------
   tsi_state_e          state_q;
   logic [NE-1:0]       pend_q;
   logic [1:0]          wsel_q;
   logic [AW-1:0]       eff_q;
   logic [VLEN-1:0]     a_q, b_q, c_q;

   logic [IW-1:0]       cur_idx;
   logic [NE-1:0]       cur_oh;
   logic                cur_any;
   logic [NE-1:0]       pend_left;
   logic                beat_ok;

   tsi_first_set #(.N(NE), .IW(IW)) u_pick (
      .req    (pend_q),
      .idx    (cur_idx),
      .onehot (cur_oh),
      .any    (cur_any)
   );

   tsi_word_mux #(.LANES(NE), .IW(IW), .EW(ELEM_W)) u_mux (
      .va   (a_q),
      .vb   (b_q),
      .vc   (c_q),
      .idx  (cur_idx),
      .wsel (wsel_q),
      .word (mem_data)
   );

   assign pend_left = pend_q & ~cur_oh;
   assign beat_ok   = mem_valid && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= '0;
         wsel_q      <= '0;
         eff_q       <= '0;
         err_illegal <= 1'b0;
         err_fault   <= 1'b0;
         fault_elem  <= '0;
         reg_sel     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  eff_q       <= eff_c;
                  reg_sel     <= sel_c;
                  wsel_q      <= '0;
                  err_illegal <= !legal_c;
                  err_fault   <= 1'b0;
                  fault_elem  <= '0;
                  pend_q      <= legal_c ? act_c : '0;
                  state_q     <= (legal_c && (act_c != '0)) ? ST_RUN : ST_FIN;
               end
            end
            ST_RUN: begin
               if (beat_ok) begin
                  if (mem_fault) begin
                     err_fault  <= 1'b1;
                     fault_elem <= cur_idx;
                     pend_q     <= '0;
                     state_q    <= ST_FIN;
                  end else if (wsel_q == 2'd2) begin
                     wsel_q <= '0;
                     pend_q <= pend_left;
                     if (pend_left == '0) state_q <= ST_FIN;
                  end else begin
                     wsel_q <= wsel_q + 2'd1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_IDLE && start) begin
         a_q <= vec_a;
         b_q <= vec_b;
         c_q <= vec_c;
      end
   end

   // ---------------------------------------------------------------
   // Outputs
   // ---------------------------------------------------------------
   assign busy      = (state_q == ST_RUN);
   assign done      = (state_q == ST_FIN);
   assign mem_valid = (state_q == ST_RUN) && cur_any;
   assign mem_strb  = {WORD_BYTES{1'b1}};
   assign mem_addr  = eff_q + AW'(cur_idx) * AW'(STRUCT_BYTES)
                            + AW'(wsel_q) * AW'(WORD_BYTES);
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker #(
   parameter int AW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err_illegal,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic          mem_fault,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_data
);
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

   assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && !mem_fault |=> !mem_valid || (mem_addr > $past(mem_addr)));

   assert_no_write_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_illegal |-> !mem_valid);

   assert_fault_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && mem_fault |=> done && !mem_valid);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   assert_valid_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> busy);
endmodule

bind tri_store_interleave tsi_checker #(.AW(AW)) u_tsi_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .err_illegal (err_illegal),
   .mem_valid   (mem_valid),
   .mem_ready   (mem_ready),
   .mem_fault   (mem_fault),
   .mem_addr    (mem_addr),
   .mem_data    (mem_data)
);

// File: tb/tb_tri_store_interleave.sv
module tb_tri_store_interleave;
   localparam int CLK_PERIOD = 10;
   localparam int VLEN = 128;
   localparam int NE   = VLEN / 32;
   localparam int PW   = VLEN / 8;

   typedef struct packed {
      logic [63:0] base;
      logic [5:0]  imm;
      logic [4:0]  first;
      logic [15:0] pred;
      logic        stall;
      logic [4:0]  fbeat;   // 31 = no fault
   } tcase_t;

   localparam int NCASE = 9;
   localparam tcase_t CASES [NCASE] = '{
      '{64'h0000_1000, 6'd0,  5'd3,  16'h1111, 1'b0, 5'd31},  // all active
      '{64'h0000_2000, 6'd3,  5'd31, 16'h0101, 1'b1, 5'd31},  // wrap, sparse, stall
      '{64'h0000_8000, 6'h28, 5'd30, 16'hF0F1, 1'b0, 5'd31},  // imm -24
      '{64'h0000_4000, 6'd21, 5'd0,  16'hEEEE, 1'b0, 5'd31},  // none active
      '{64'h0000_5000, 6'd1,  5'd7,  16'hFFFF, 1'b0, 5'd31},  // illegal: not multiple
      '{64'h0000_5000, 6'd24, 5'd7,  16'hFFFF, 1'b0, 5'd31},  // illegal: above range
      '{64'h0000_6000, 6'h3D, 5'd12, 16'h1111, 1'b0, 5'd4},   // imm -3, fault elem 1
      '{64'h0000_7000, 6'd6,  5'd29, 16'h1010, 1'b1, 5'd0},   // fault on first beat
      '{64'h0000_9000, 6'h25, 5'd1,  16'h1111, 1'b0, 5'd31}   // illegal: -27
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   base_addr = '0;
   logic [5:0]    imm_vl = '0;
   logic [4:0]    first_reg = '0;
   logic [VLEN-1:0] vec_a = '0, vec_b = '0, vec_c = '0;
   logic [PW-1:0] pred = '0;
   logic          busy, done, err_illegal, err_fault;
   logic [1:0]    fault_elem;
   logic [14:0]   reg_sel;
   logic          mem_valid;
   logic          mem_ready = 1'b0;
   logic [63:0]   mem_addr;
   logic [31:0]   mem_data;
   logic [3:0]    mem_strb;
   logic          mem_fault = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tri_store_interleave #(.VLEN(VLEN)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .imm_vl(imm_vl), .first_reg(first_reg), .vec_a(vec_a), .vec_b(vec_b),
      .vec_c(vec_c), .pred(pred), .busy(busy), .done(done),
      .err_illegal(err_illegal), .err_fault(err_fault), .fault_elem(fault_elem),
      .reg_sel(reg_sel), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
      .mem_fault(mem_fault)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] elem_val(input int src, input int cidx, input int i);
      return 32'(32'hA000_0000 + (src << 24) + (cidx << 8) + i);
   endfunction

   task automatic run_op(input int cidx, input tcase_t tc, input bit hold_start);
      logic [63:0] exp_addr [12];
      logic [31:0] exp_data [12];
      int          exp_elem [12];
      int          n = 0;
      int          k = 0;
      int          done_cyc = -1;
      int          last_acc = -1;
      int          fault_el = 0;
      bit          faulted = 0;
      bit          prev_stall = 0;
      logic [63:0] prev_addr = '0;
      logic [31:0] prev_data = '0;
      int          imm_i = int'($signed(tc.imm));
      bit          legal = (imm_i >= -24) && (imm_i <= 21) && (imm_i % 3 == 0);
      logic [63:0] ea = tc.base + 64'(longint'(imm_i) * (VLEN / 8));
      int          f = int'(tc.first);
      logic [14:0] exp_sel = {5'((f + 2) % 32), 5'((f + 1) % 32), 5'(f)};

      for (int i = 0; i < NE; i++) begin
         if (legal && tc.pred[4*i]) begin
            for (int w = 0; w < 3; w++) begin
               exp_addr[n] = ea + 64'(12 * i + 4 * w);
               exp_data[n] = elem_val(w, cidx, i);
               exp_elem[n] = i;
               n++;
            end
         end
      end

      @(negedge clk);
      base_addr = tc.base;
      imm_vl    = tc.imm;
      first_reg = tc.first;
      pred      = tc.pred;
      for (int i = 0; i < NE; i++) begin
         vec_a[32*i +: 32] = elem_val(0, cidx, i);
         vec_b[32*i +: 32] = elem_val(1, cidx, i);
         vec_c[32*i +: 32] = elem_val(2, cidx, i);
      end
      start = 1'b1;
      @(negedge clk);
      start = hold_start;
      if (hold_start) begin
         base_addr = 64'hDEAD_0000;
         imm_vl    = 6'd1;
         pred      = '1;
      end

      for (int cyc = 0; cyc < 100; cyc++) begin
         mem_ready = tc.stall ? (cyc % 3 != 1) : 1'b1;
         mem_fault = (k == int'(tc.fbeat));
         if (done) begin
            done_cyc = cyc;
            break;
         end
         if (cyc == 0 && n > 0)
            check(busy === 1'b1, "R8", "busy after start", busy, 1);
         if (mem_valid) begin
            if (prev_stall) begin
               check(mem_addr === prev_addr, "R4", "addr held in stall", mem_addr, prev_addr);
               check(mem_data === prev_data, "R4", "data held in stall", mem_data, prev_data);
            end
            if (mem_ready) begin
               if (k < n) begin
                  check(mem_addr === exp_addr[k], "R1", "beat addr", mem_addr, exp_addr[k]);
                  check(mem_data === exp_data[k], "R1", "beat data", mem_data, exp_data[k]);
               end else begin
                  check(1'b0, "R3", "unexpected beat", k, n);
               end
               check(mem_strb === 4'hF, "R4", "strobes", mem_strb, 4'hF);
               if (mem_fault) begin
                  faulted  = 1;
                  fault_el = exp_elem[k];
               end
               k++;
               last_acc = cyc;
            end
         end
         prev_stall = mem_valid && !mem_ready;
         prev_addr  = mem_addr;
         prev_data  = mem_data;
         @(negedge clk);
      end
      start     = 1'b0;
      mem_ready = 1'b0;
      mem_fault = 1'b0;

      if (!legal) begin
         check(err_illegal === 1'b1, "R5", "illegal flag", err_illegal, 1);
         check(done_cyc == 0, "R5", "illegal done cycle", done_cyc, 0);
         check(k == 0, "R5", "illegal beat count", k, 0);
      end else begin
         check(err_illegal === 1'b0, "R5", "legal flag", err_illegal, 0);
         check(k == (faulted ? int'(tc.fbeat) + 1 : n), "R3", "beat count", k, n);
         check(done_cyc == ((k == 0) ? 0 : last_acc + 1), "R8", "done cycle",
               done_cyc, last_acc + 1);
         check(err_fault === faulted, "R7", "fault flag", err_fault, faulted);
         if (faulted)
            check(int'(fault_elem) == fault_el, "R7", "fault element", fault_elem, fault_el);
      end
      check(busy === 1'b0, "R8", "busy low at done", busy, 0);
      check(reg_sel === exp_sel, "R6", "register indices", reg_sel, exp_sel);
      @(negedge clk);
      check(done === 1'b0, "R8", "done one cycle", done, 0);
      check(mem_valid === 1'b0, "R8", "idle after done", mem_valid, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R8 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      tcase_t t;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(busy === 1'b0, "R9", "busy in reset", busy, 0);
      check(done === 1'b0, "R9", "done in reset", done, 0);
      check(mem_valid === 1'b0, "R9", "valid in reset", mem_valid, 0);
      check(err_illegal === 1'b0 && err_fault === 1'b0, "R9", "errors in reset",
            {err_illegal, err_fault}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R6 R7: table walk
      for (int c = 0; c < NCASE; c++) run_op(c, CASES[c], 1'b0);

      // R8: start held high during a run is ignored
      t = '{64'h0000_3000, 6'd9, 5'd5, 16'h1011, 1'b1, 5'd31};
      run_op(20, t, 1'b1);

      // R3: ignored predicate bits set, element 2 only active
      t = '{64'h0001_0000, 6'h3A, 5'd31, 16'h0EF1 & 16'h0E00 | 16'h0100, 1'b0, 5'd31};
      run_op(21, t, 1'b0);

      // R7: fault on last word of last active element
      t = '{64'h0002_0000, 6'd0, 5'd2, 16'h1001, 1'b1, 5'd5};
      run_op(22, t, 1'b0);

      // R9: reset in the middle of an operation
      @(negedge clk);
      pred = 16'h1111; imm_vl = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(busy === 1'b0 && mem_valid === 1'b0, "R9", "reset aborts run",
            {busy, mem_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule